// File: doc/BRIEF.md
# Byte-Loaded Rate Generator Counter

This block is a programmable clock divider that paces pattern output. It emits a periodic active-low strobe that lasts one clock. Software first writes a command byte that selects the count length: 8-bit or 16-bit. It then writes the count one byte at a time on a separate count-write strobe. A 16-bit count takes two writes, low byte before high byte. The divider starts only when the whole count has arrived, and it then reloads itself at the end of every period.

A second active-low output, the request line, carries the same pulse, but only while the handshake-enable input is high. A pattern port uses this line to move its staged word to the output pins once per period. Both outputs come from registers. A count value of zero stands for the largest count of the selected length.

Top module: `rate_pacer`

## Requirements
- R1: After a synchronous reset, `strobe_n` and `req_n` are high, the divider is stopped, the length is 8-bit, and the next count byte is treated as a low byte.
- R2: Command byte 0x14 selects 8-bit length. A single count byte N then starts the divider. `strobe_n` is low in the clock that follows the Nth rising edge after the edge that took the count byte, and again every N edges after that. No strobe appears before a count is complete.
- R3: For N of 2 or more, each low pulse of `strobe_n` lasts exactly one clock. For N = 1, `strobe_n` stays low continuously while the divider runs.
- R4: Command byte 0x34 selects 16-bit length. The first count byte is the low byte and the second is the high byte, and the period is high*256+low. Writing the low byte stops the divider, and it stays stopped until the high byte arrives.
- R5: A count of zero means 256 in 8-bit length and 65536 in 16-bit length.
- R6: Writing 0x14 or 0x34 stops the divider: `strobe_n` is high from the next edge until a new count completes. The same write returns the byte pointer to the low byte.
- R7: A command write of any other value has no effect. The length, the pointer and the running period all continue unchanged.
- R8: A count write in the same cycle as a command write is ignored.
- R9: `req_n` is low in exactly those clocks in which `strobe_n` is low and `hs_en` was high at the edge that started the pulse. In all other clocks `req_n` is high.
- R10: In 8-bit length, a count write while the divider runs restarts the period from that write, using the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| cnt_we | input | 1 | Count byte write strobe |
| cnt_data | input | BYTE_W | Count byte |
| hs_en | input | 1 | Routes the strobe to the request line |
| strobe_n | output | 1 | Active-low rate strobe, one clock wide |
| req_n | output | 1 | Active-low request to the pattern port |

## Verification
A wrong down-counter value or reload register moves the next strobe away from its expected edge. The error is visible at the ports within one period. A wrong length flag or byte pointer shows up when the next count completes: the period comes out with the wrong value, or it starts one write too early or too late. The bench keeps a cycle model of the period and compares both outputs on every clock. Any such fault is therefore reported in the first clock that differs.

// File: rtl/rate_pacer_pkg.sv
package rate_pacer_pkg;
  typedef enum logic {LEN_SHORT = 1'b0, LEN_LONG = 1'b1} len_e;
  localparam logic [7:0] OP_RATE_SHORT = 8'h14;
  localparam logic [7:0] OP_RATE_LONG  = 8'h34;
endpackage

// File: rtl/rp_loader.sv
module rp_loader
  import rate_pacer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_data,
  input  logic              cnt_we,
  input  logic [BYTE_W-1:0] cnt_data,
  output logic              load,
  output logic              halt,
  output logic [CNT_W-1:0]  load_val
);
  len_e              len_q;
  logic              ptr_hi_q;
  logic [BYTE_W-1:0] lo_q;
  logic              op_short, op_long, op_ok, byte_ok;
  logic [BYTE_W-1:0] short_m1;
  logic [CNT_W-1:0]  long_m1;

  always_comb begin
    op_short = cmd_we && (cmd_data == OP_RATE_SHORT);
    op_long  = cmd_we && (cmd_data == OP_RATE_LONG);
    op_ok    = op_short || op_long;
    byte_ok  = cnt_we && !cmd_we;
    load     = byte_ok && ((len_q == LEN_SHORT) || ptr_hi_q);
    halt     = op_ok || (byte_ok && (len_q == LEN_LONG) && !ptr_hi_q);
    short_m1 = cnt_data - BYTE_W'(1);
    long_m1  = {cnt_data, lo_q} - CNT_W'(1);
    load_val = (len_q == LEN_SHORT) ? {{BYTE_W{1'b0}}, short_m1} : long_m1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= LEN_SHORT;
      ptr_hi_q <= 1'b0;
      lo_q     <= '0;
    end else if (op_ok) begin
      len_q    <= op_long ? LEN_LONG : LEN_SHORT;
      ptr_hi_q <= 1'b0;
    end else if (byte_ok && (len_q == LEN_LONG)) begin
      if (!ptr_hi_q) begin
        lo_q     <= cnt_data;
        ptr_hi_q <= 1'b1;
      end else begin
        ptr_hi_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rp_divider.sv
module rp_divider #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             halt,
  input  logic [CNT_W-1:0] load_val,
  output logic             tick,
  output logic             strobe_n,
  output logic             run_o,
  output logic [CNT_W-1:0] reload_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q, reload_q;

  assign tick     = run_q && (cnt_q == '0) && !load && !halt;
  assign run_o    = run_q;
  assign reload_o = reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      reload_q <= '0;
      strobe_n <= 1'b1;
    end else begin
      strobe_n <= ~tick;
      if (halt) begin
        run_q <= 1'b0;
      end else if (load) begin
        run_q    <= 1'b1;
        cnt_q    <= load_val;
        reload_q <= load_val;
      end else if (run_q) begin
        cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rp_req_gate.sv
module rp_req_gate (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hs_en,
  output logic req_n
);
  always_ff @(posedge clk) begin
    if (rst) req_n <= 1'b1;
    else     req_n <= ~(tick && hs_en);
  end
endmodule

// File: rtl/rate_pacer.sv
module rate_pacer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_data,
  input  logic              cnt_we,
  input  logic [BYTE_W-1:0] cnt_data,
  input  logic              hs_en,
  output logic              strobe_n,
  output logic              req_n
);
  localparam int CNT_W = 2 * BYTE_W;

  logic             load_w, halt_w, tick_w, run_w;
  logic [CNT_W-1:0] load_val_w, reload_w;

  rp_loader #(.BYTE_W(BYTE_W)) u_load (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .cnt_we(cnt_we), .cnt_data(cnt_data),
    .load(load_w), .halt(halt_w), .load_val(load_val_w)
  );

  rp_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .load(load_w), .halt(halt_w), .load_val(load_val_w),
    .tick(tick_w), .strobe_n(strobe_n), .run_o(run_w), .reload_o(reload_w)
  );

  rp_req_gate u_gate (
    .clk(clk), .rst(rst), .tick(tick_w), .hs_en(hs_en), .req_n(req_n)
  );
endmodule

// File: rtl/rate_pacer_chk.sv
module rate_pacer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_we,
  input logic [7:0]       cmd_data,
  input logic             hs_en,
  input logic             strobe_n,
  input logic             req_n,
  input logic             run,
  input logic             load,
  input logic [CNT_W-1:0] reload
);
  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (strobe_n && req_n)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> strobe_n); // R2

  AST_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    (!strobe_n && reload != '0) |=> strobe_n); // R3

  AST_CMD_HALT: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && (cmd_data == 8'h14 || cmd_data == 8'h34)) |=> (strobe_n && !run)); // R6

  AST_REQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !hs_en |=> req_n); // R9

  AST_REQ_TRACK: assert property (@(posedge clk) disable iff (rst)
    hs_en |=> (req_n == strobe_n)); // R9
endmodule

bind rate_pacer rate_pacer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data), .hs_en(hs_en),
  .strobe_n(strobe_n), .req_n(req_n), .run(run_w), .load(load_w), .reload(reload_w)
);

// File: tb/tb_rate_pacer.sv
module tb_rate_pacer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_data = 8'h00;
  logic       hs_en = 1'b0;
  logic       strobe_n, req_n;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit m_run = 0, m_long = 0, m_ptr = 0, exp_s = 1, exp_r = 1;
  int m_period = 1, m_left = 0, m_lo = 0;

  rate_pacer dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .cnt_we(cnt_we), .cnt_data(cnt_data), .hs_en(hs_en),
    .strobe_n(strobe_n), .req_n(req_n)
  );

  always #10 clk = ~clk;

  function automatic bit valid_op(input logic [7:0] b);
    return (b == 8'h14) || (b == 8'h34);
  endfunction

  function automatic int span(input bit is_long, input int hi, input int lo);
    int v;
    v = is_long ? (hi * 256 + lo) : lo;
    if (v == 0) v = is_long ? 65536 : 256;
    return v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    exp_s = 1;
    if (rst) begin
      m_run = 0; m_long = 0; m_ptr = 0; m_lo = 0;
    end else if (cmd_we && valid_op(cmd_data)) begin
      m_long = (cmd_data == 8'h34); m_ptr = 0; m_run = 0;
    end else if (cnt_we && !cmd_we) begin
      if (!m_long) begin
        m_period = span(0, 0, cnt_data); m_left = m_period; m_run = 1;
      end else if (!m_ptr) begin
        m_lo = cnt_data; m_ptr = 1; m_run = 0;
      end else begin
        m_period = span(1, cnt_data, m_lo); m_left = m_period; m_run = 1; m_ptr = 0;
      end
    end else if (m_run) begin
      m_left--;
      if (m_left == 0) begin exp_s = 0; m_left = m_period; end
    end
    exp_r = !(!exp_s && hs_en && !rst);
  end

  always @(negedge clk) begin
    if (chk_on) begin
      n_chk++;
      if (strobe_n !== exp_s || req_n !== exp_r) begin
        n_fail++;
        $display("FAIL %s cycle %0d: strobe_n=%b exp=%b req_n=%b exp=%b",
                 cur_req, cyc, strobe_n, exp_s, req_n, exp_r);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc >= 190000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr_cmd(input logic [7:0] b);
    @(negedge clk); cmd_we = 1; cmd_data = b;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic wr_cnt(input logic [7:0] b);
    @(negedge clk); cnt_we = 1; cnt_data = b;
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic wr_both(input logic [7:0] c, input logic [7:0] b);
    @(negedge clk); cmd_we = 1; cmd_data = c; cnt_we = 1; cnt_data = b;
    @(negedge clk); cmd_we = 0; cnt_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    chk_on = 1;
    cur_req = "R1";
    idle(5);

    cur_req = "R2"; hs_en = 1;
    wr_cmd(8'h14); wr_cnt(8'd5); idle(30);
    cur_req = "R3";
    wr_cnt(8'd1); idle(6); wr_cnt(8'd2); idle(9);
    cur_req = "R4";
    wr_cmd(8'h34); wr_cnt(8'h03); idle(12); wr_cnt(8'h01); idle(600);
    cur_req = "R5";
    wr_cmd(8'h14); wr_cnt(8'h00); idle(540);
    wr_cmd(8'h34); wr_cnt(8'h00); wr_cnt(8'h00); idle(65560);
    cur_req = "R6";
    wr_cmd(8'h14); wr_cnt(8'd3); idle(5); wr_cmd(8'h14); idle(20);
    wr_cmd(8'h34); wr_cnt(8'd7); wr_cmd(8'h34); wr_cnt(8'd4); wr_cnt(8'd0); idle(20);
    cur_req = "R7";
    wr_cmd(8'h14); wr_cnt(8'd6); idle(4); wr_cmd(8'h55); wr_cmd(8'h24); idle(20);
    wr_cnt(8'd3); idle(10);
    cur_req = "R8";
    wr_both(8'h34, 8'd9); wr_cnt(8'd2); wr_cnt(8'd0); idle(12);
    wr_both(8'h77, 8'd1); idle(10);
    cur_req = "R9";
    wr_cmd(8'h14); wr_cnt(8'd3); hs_en = 0; idle(10); hs_en = 1; idle(7);
    @(negedge clk); hs_en = 0; idle(2); hs_en = 1; idle(5);
    cur_req = "R10";
    wr_cnt(8'd10); idle(4); wr_cnt(8'd3); idle(12);

    cur_req = "R2/R4 random";
    for (int i = 0; i < 2500; i++) begin
      int r;
      r = $urandom % 10;
      case (r)
        0: wr_cmd(($urandom % 2) ? 8'h14 : 8'h34);
        1: wr_cmd(8'($urandom));
        2, 3, 4, 5: wr_cnt(8'($urandom % 12));
        6: wr_both(($urandom % 2) ? 8'h14 : 8'($urandom), 8'($urandom % 8));
        7: begin @(negedge clk); hs_en = ~hs_en; end
        default: idle($urandom % 6);
      endcase
    end
    idle(20);
    chk_on = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule